// File: doc/BRIEF.md
# Vectored Nesting Interrupt Controller

This block collects 32 interrupt request lines from peripherals and presents two active-low request lines to a processor: a normal interrupt request (IRQ) and a fast interrupt request (FIQ). Software configures it through a small word-addressed register port. Each source can be enabled and routed to either output. Requests can also be raised and removed by software. Sixteen vectored slots each bind one source to a handler address. Slot 0 has the highest priority. A programmable default address covers active IRQ sources that no enabled slot names.

The vector register drives hardware nesting. A read returns the handler address of the best request that is allowed to interrupt, and marks that priority level as in service. While a level is in service, only strictly higher-priority requests drive IRQ. Any write to the vector register ends the most recently entered level, which is the highest-priority level in service. Software that polls the status registers alone never touches the vector register.

A second controller further from the processor can feed this one through chain inputs: an active-low IRQ, an active-low FIQ and a 32-bit vector. A chained FIQ passes straight through. A chained IRQ is forwarded only when no local IRQ request qualifies, and its vector then appears both on a vector read and on the vector output, so that this block can itself sit lower in a chain. To use the block standalone, tie both chain request inputs high and the chain vector to zero.

Top module: `irqn_ctrl`

## Requirements
- R1: After reset, irq_n_o and fiq_n_o are high, and the enable, FIQ-select, software-request and slot registers all read zero.
- R2: Raw status (offset 0x02) reads src_i OR the software request bits. A write to offset 0x05 sets the software bits where the data has ones. A write to offset 0x06 clears the software bits where the data has ones.
- R3: IRQ status (offset 0x00) reads raw AND enable (0x03) AND NOT FIQ-select (0x04). FIQ status (offset 0x01) reads raw AND enable AND FIQ-select.
- R4: fiq_n_o is low exactly when FIQ status is nonzero or chain_fiq_n_i is low.
- R5: A slot's handler address is at 0x10+slot and its control word at 0x20+slot (bit 8 enable, bits 4:0 source). A read of the vector register (offset 0x07) returns the address of the lowest-numbered enabled slot whose source is IRQ-active.
- R6: When no slot qualifies and an IRQ-active source is named by no enabled slot, irq_n_o is low and a vector read returns the default address (offset 0x08).
- R7: A vector read that returns a request marks its level as in service. From then on, irq_n_o is driven low only by requests of strictly higher priority (a lower slot number; any slot ranks above default, and default ranks above chain).
- R8: Any write to the vector register, whatever the data, ends the highest-priority level in service, so that requests at or below it drive irq_n_o again.
- R9: When no local request qualifies and chain_irq_n_i is low, irq_n_o is low, and both a vector read and vec_o give chain_vec_i. Any qualifying local request takes priority over the chain.
- R10: With the chain inputs idle and no IRQ-active source, irq_n_o is high, whatever the in-service state.
- R11: A vector read while no request qualifies returns the default address and leaves the in-service state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Peripheral interrupt request lines, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on the vector register) |
| reg_addr | input | 6 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| chain_irq_n_i | input | 1 | IRQ from a downstream controller, active low |
| chain_fiq_n_i | input | 1 | FIQ from a downstream controller, active low |
| chain_vec_i | input | 32 | Vector address from a downstream controller |
| irq_n_o | output | 1 | IRQ to the processor, active low |
| fiq_n_o | output | 1 | FIQ to the processor, active low |
| vec_o | output | 32 | Currently selected vector, for an upstream controller |

## Verification
A corrupt in-service record shows on irq_n_o in the cycle after the vector access that caused it. A level that should have been entered leaves irq_n_o low for a request of equal priority. A level that failed to be removed keeps irq_n_o high after the pop while the same source is still active. A wrong priority choice shows at once in the value of the vector read and on vec_o, because both come straight from combinational selection. The sweeps bind every slot to its own source, so a slip in any slot's decoding or ordering returns a wrong address at the very read that should hit it.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
   localparam int unsigned REG_AW = 6;

   localparam logic [REG_AW-1:0] OFS_IRQ_STAT  = 6'h00;
   localparam logic [REG_AW-1:0] OFS_FIQ_STAT  = 6'h01;
   localparam logic [REG_AW-1:0] OFS_RAW_STAT  = 6'h02;
   localparam logic [REG_AW-1:0] OFS_ENABLE    = 6'h03;
   localparam logic [REG_AW-1:0] OFS_FIQ_SEL   = 6'h04;
   localparam logic [REG_AW-1:0] OFS_SOFT_SET  = 6'h05;
   localparam logic [REG_AW-1:0] OFS_SOFT_CLR  = 6'h06;
   localparam logic [REG_AW-1:0] OFS_VECTOR    = 6'h07;
   localparam logic [REG_AW-1:0] OFS_DEFAULT   = 6'h08;
   localparam logic [REG_AW-1:0] OFS_SLOT_ADDR = 6'h10;
   localparam logic [REG_AW-1:0] OFS_SLOT_CTL  = 6'h20;

   localparam int unsigned CTL_EN_BIT = 8;
   localparam int unsigned MAX_SLOTS  = 16;

   typedef enum logic [1:0] {
      PICK_NONE,
      PICK_SLOT,
      PICK_DEFAULT,
      PICK_CHAIN
   } pick_e;
endpackage

// File: rtl/irqn_regs.sv
module irqn_regs
   import irqn_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned N_SLOT = 16,
   parameter int unsigned DW     = 32,
   localparam int unsigned SW    = $clog2(N_SRC)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_SRC-1:0]             src_i,
   input  logic                         wr,
   input  logic [REG_AW-1:0]            addr,
   input  logic [DW-1:0]                wdata,
   input  logic [DW-1:0]                vec_value,
   output logic [DW-1:0]                rdata,
   output logic [N_SRC-1:0]             irq_act,
   output logic [N_SRC-1:0]             fiq_act,
   output logic [N_SLOT-1:0]            slot_en,
   output logic [N_SLOT-1:0][SW-1:0]    slot_src,
   output logic [N_SLOT-1:0][DW-1:0]    slot_addr,
   output logic [DW-1:0]                dflt_addr
);
   logic [N_SRC-1:0] enable_q, fiq_sel_q, soft_q, raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q  <= '0;
         fiq_sel_q <= '0;
         soft_q    <= '0;
         dflt_addr <= '0;
      end else if (wr) begin
         case (addr)
            OFS_ENABLE:   enable_q  <= wdata[N_SRC-1:0];
            OFS_FIQ_SEL:  fiq_sel_q <= wdata[N_SRC-1:0];
            OFS_SOFT_SET: soft_q    <= soft_q | wdata[N_SRC-1:0];
            OFS_SOFT_CLR: soft_q    <= soft_q & ~wdata[N_SRC-1:0];
            OFS_DEFAULT:  dflt_addr <= wdata;
            default: ;
         endcase
      end
   end

   for (genvar gi = 0; gi < N_SLOT; gi++) begin : g_slot
      logic hit_addr, hit_ctl;
      assign hit_addr = wr && (addr == OFS_SLOT_ADDR + REG_AW'(gi));
      assign hit_ctl  = wr && (addr == OFS_SLOT_CTL + REG_AW'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_addr[gi] <= '0;
            slot_en[gi]   <= 1'b0;
            slot_src[gi]  <= '0;
         end else begin
            if (hit_addr) slot_addr[gi] <= wdata;
            if (hit_ctl) begin
               slot_en[gi]  <= wdata[CTL_EN_BIT];
               slot_src[gi] <= wdata[SW-1:0];
            end
         end
      end
   end

   assign raw     = src_i | soft_q;
   assign irq_act = raw & enable_q & ~fiq_sel_q;
   assign fiq_act = raw & enable_q & fiq_sel_q;

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_IRQ_STAT: rdata = DW'(irq_act);
         OFS_FIQ_STAT: rdata = DW'(fiq_act);
         OFS_RAW_STAT: rdata = DW'(raw);
         OFS_ENABLE:   rdata = DW'(enable_q);
         OFS_FIQ_SEL:  rdata = DW'(fiq_sel_q);
         OFS_SOFT_SET: rdata = DW'(soft_q);
         OFS_VECTOR:   rdata = vec_value;
         OFS_DEFAULT:  rdata = dflt_addr;
         default: ;
      endcase
      for (int i = 0; i < N_SLOT; i++) begin
         if (addr == OFS_SLOT_ADDR + REG_AW'(i)) rdata = slot_addr[i];
         if (addr == OFS_SLOT_CTL + REG_AW'(i)) begin
            rdata[CTL_EN_BIT] = slot_en[i];
            rdata[SW-1:0]     = slot_src[i];
         end
      end
   end

   // R2: a clear write leaves none of its bits set in the software request
   a_r2_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == OFS_SOFT_CLR) |=> ((soft_q & $past(wdata[N_SRC-1:0])) == '0));

   // R3: a source cannot be reported on both outputs at once
   a_r3_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_act & fiq_act) == '0);
endmodule

// File: rtl/irqn_prio.sv
module irqn_prio
   import irqn_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned N_SLOT = 16,
   parameter int unsigned DW     = 32,
   localparam int unsigned SW    = $clog2(N_SRC),
   localparam int unsigned LW    = $clog2(N_SLOT + 3)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_SRC-1:0]             irq_act,
   input  logic [N_SLOT-1:0]            slot_en,
   input  logic [N_SLOT-1:0][SW-1:0]    slot_src,
   input  logic [N_SLOT-1:0][DW-1:0]    slot_addr,
   input  logic [DW-1:0]                dflt_addr,
   input  logic                         chain_irq_n,
   input  logic [DW-1:0]                chain_vec,
   input  logic [LW-1:0]                cur_lvl,
   output logic                         req_valid,
   output logic [LW-1:0]                req_lvl,
   output logic [DW-1:0]                req_vec,
   output pick_e                        pick
);
   localparam logic [LW-1:0] LVL_DEFAULT = LW'(N_SLOT);
   localparam logic [LW-1:0] LVL_CHAIN   = LW'(N_SLOT + 1);

   logic [N_SLOT-1:0] hit;
   logic [N_SRC-1:0]  mapped;
   logic [LW-1:0]     best;
   logic              found, dflt_pend;

   for (genvar gi = 0; gi < N_SLOT; gi++) begin : g_hit
      assign hit[gi] = slot_en[gi] & irq_act[slot_src[gi]];
   end

   always_comb begin
      mapped = '0;
      for (int i = 0; i < N_SLOT; i++)
         if (slot_en[i]) mapped[slot_src[i]] = 1'b1;
   end

   assign dflt_pend = |(irq_act & ~mapped);

   always_comb begin
      found = 1'b0;
      best  = '0;
      for (int i = N_SLOT - 1; i >= 0; i--) begin
         if (hit[i]) begin
            found = 1'b1;
            best  = LW'(i);
         end
      end
   end

   always_comb begin
      pick    = PICK_NONE;
      req_lvl = LVL_CHAIN + LW'(1);
      req_vec = dflt_addr;
      if (found && best < cur_lvl) begin
         pick    = PICK_SLOT;
         req_lvl = best;
         req_vec = slot_addr[best];
      end else if (dflt_pend && LVL_DEFAULT < cur_lvl) begin
         pick    = PICK_DEFAULT;
         req_lvl = LVL_DEFAULT;
      end else if (!chain_irq_n && LVL_CHAIN < cur_lvl) begin
         pick    = PICK_CHAIN;
         req_lvl = LVL_CHAIN;
         req_vec = chain_vec;
      end
   end

   assign req_valid = (pick != PICK_NONE);

   // R7: a request only qualifies above the level now in service
   a_r7_strict_level: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_lvl < cur_lvl));

   // R9: the chain is never picked while a local request qualifies
   a_r9_local_first: assert property (@(posedge clk) disable iff (!rst_n)
      (pick == PICK_CHAIN) |-> (!(found && best < cur_lvl) && !(dflt_pend && LVL_DEFAULT < cur_lvl)));
endmodule

// File: rtl/irqn_nest.sv
module irqn_nest #(
   parameter int unsigned N_SLOT = 16,
   localparam int unsigned NLVL  = N_SLOT + 2,
   localparam int unsigned LW    = $clog2(N_SLOT + 3)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [LW-1:0] push_lvl,
   input  logic          pop,
   output logic [LW-1:0] cur_lvl
);
   logic [NLVL-1:0] isr_q, isr_d;
   logic            busy;

   always_comb begin
      busy    = 1'b0;
      cur_lvl = LW'(NLVL);
      for (int i = NLVL - 1; i >= 0; i--) begin
         if (isr_q[i]) begin
            busy    = 1'b1;
            cur_lvl = LW'(i);
         end
      end
   end

   always_comb begin
      isr_d = isr_q;
      if (pop && busy) isr_d[cur_lvl] = 1'b0;
      if (push) isr_d[push_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_d;
   end

   // R7: an entered level is recorded as in service
   a_r7_push_marks: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> isr_q[$past(push_lvl)]);

   // R8: a pop removes exactly one level when any is in service
   a_r8_pop_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && busy) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/irqn_ctrl.sv
module irqn_ctrl
   import irqn_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned N_SLOT = 16,
   parameter int unsigned DW     = 32,
   localparam int unsigned SW    = $clog2(N_SRC),
   localparam int unsigned LW    = $clog2(N_SLOT + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic              chain_irq_n_i,
   input  logic              chain_fiq_n_i,
   input  logic [DW-1:0]     chain_vec_i,
   output logic              irq_n_o,
   output logic              fiq_n_o,
   output logic [DW-1:0]     vec_o
);
   if (N_SLOT < 1 || N_SLOT > MAX_SLOTS) begin : g_bad_slots
      $error("N_SLOT must lie in 1..16");
   end
   if (N_SRC < 2 || N_SRC > DW) begin : g_bad_src
      $error("N_SRC must lie in 2..DW");
   end
   if (SW > CTL_EN_BIT) begin : g_bad_sw
      $error("source select overlaps the slot enable bit");
   end

   logic [N_SRC-1:0]          irq_act, fiq_act;
   logic [N_SLOT-1:0]         slot_en;
   logic [N_SLOT-1:0][SW-1:0] slot_src;
   logic [N_SLOT-1:0][DW-1:0] slot_addr;
   logic [DW-1:0]             dflt_addr, req_vec;
   logic [LW-1:0]             cur_lvl, req_lvl;
   logic                      req_valid, push, pop;
   pick_e                     pick;

   irqn_regs #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .vec_value(req_vec), .rdata(reg_rdata),
      .irq_act(irq_act), .fiq_act(fiq_act), .slot_en(slot_en),
      .slot_src(slot_src), .slot_addr(slot_addr), .dflt_addr(dflt_addr)
   );

   irqn_prio #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW)) u_prio (
      .clk(clk), .rst_n(rst_n), .irq_act(irq_act), .slot_en(slot_en),
      .slot_src(slot_src), .slot_addr(slot_addr), .dflt_addr(dflt_addr),
      .chain_irq_n(chain_irq_n_i), .chain_vec(chain_vec_i), .cur_lvl(cur_lvl),
      .req_valid(req_valid), .req_lvl(req_lvl), .req_vec(req_vec), .pick(pick)
   );

   assign push = reg_rd && (reg_addr == OFS_VECTOR) && req_valid;
   assign pop  = reg_wr && (reg_addr == OFS_VECTOR);

   irqn_nest #(.N_SLOT(N_SLOT)) u_nest (
      .clk(clk), .rst_n(rst_n), .push(push), .push_lvl(req_lvl),
      .pop(pop), .cur_lvl(cur_lvl)
   );

   assign irq_n_o = ~req_valid;
   assign fiq_n_o = ~((|fiq_act) | ~chain_fiq_n_i);
   assign vec_o   = req_vec;

   // R4: a chained FIQ always reaches the processor
   a_r4_chain_fiq: assert property (@(posedge clk) disable iff (!rst_n)
      !chain_fiq_n_i |-> !fiq_n_o);

   // R10: idle chain and no IRQ-active source keep IRQ released
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_irq_n_i && irq_act == '0) |-> irq_n_o);

   // R9: a chained request drives the vector output unchanged
   a_r9_chain_out: assert property (@(posedge clk) disable iff (!rst_n)
      (pick == PICK_CHAIN) |-> (vec_o == chain_vec_i && !irq_n_o));
endmodule

// File: tb/irqn_ctrl_tb.sv
module irqn_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        chain_irq_n_i = 1'b1, chain_fiq_n_i = 1'b1;
   logic [31:0] chain_vec_i = '0;
   logic        irq_n_o, fiq_n_o;
   logic [31:0] vec_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   irqn_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .chain_irq_n_i(chain_irq_n_i), .chain_fiq_n_i(chain_fiq_n_i),
      .chain_vec_i(chain_vec_i), .irq_n_o(irq_n_o), .fiq_n_o(fiq_n_o), .vec_o(vec_o)
   );

   function automatic logic [4:0] slot_src(int i);
      return 5'((i * 5 + 2) % 32);
   endfunction
   function automatic logic [31:0] slot_adr(int i);
      return 32'h4000_0000 + 32'(i * 16);
   endfunction
   localparam logic [31:0] DFLT = 32'hDEAD_0000;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic settle;
      @(negedge clk); #1;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      settle();
      // R1 reset state
      check("R1 irq_n", 32'(irq_n_o), 32'd1);
      check("R1 fiq_n", 32'(fiq_n_o), 32'd1);
      rd_reg(6'h03, v); check("R1 enable", v, 0);
      rd_reg(6'h04, v); check("R1 fiqsel", v, 0);
      rd_reg(6'h05, v); check("R1 soft", v, 0);
      rd_reg(6'h23, v); check("R1 slot ctl", v, 0);

      // R2 software set and clear
      wr_reg(6'h05, 32'h0000_00A5);
      rd_reg(6'h02, v); check("R2 raw soft", v, 32'h0000_00A5);
      src_i = 32'h0000_0100;
      rd_reg(6'h02, v); check("R2 raw mix", v, 32'h0000_01A5);
      wr_reg(6'h06, 32'h0000_0005);
      rd_reg(6'h02, v); check("R2 raw clr", v, 32'h0000_01A0);
      wr_reg(6'h06, 32'hFFFF_FFFF);

      // R3 / R4 status and FIQ
      src_i = 32'h0003_0101;
      wr_reg(6'h05, 32'h0000_0A5A);
      wr_reg(6'h03, 32'h0000_FFF0);
      wr_reg(6'h04, 32'h0000_0F00);
      rd_reg(6'h00, v); check("R3 irq stat", v, (32'h0003_0B5B & 32'h0000_FFF0) & ~32'h0000_0F00);
      rd_reg(6'h01, v); check("R3 fiq stat", v, 32'h0003_0B5B & 32'h0000_0F00);
      check("R4 fiq low", 32'(fiq_n_o), 0);
      wr_reg(6'h04, 32'h0);
      check("R4 fiq high", 32'(fiq_n_o), 1);
      chain_fiq_n_i = 1'b0; settle();
      check("R4 chain fiq", 32'(fiq_n_o), 0);
      chain_fiq_n_i = 1'b1;
      src_i = '0;
      wr_reg(6'h06, 32'hFFFF_FFFF);
      wr_reg(6'h03, 32'hFFFF_FFFF);
      settle();
      check("R10 idle", 32'(irq_n_o), 1);

      // program slots and default
      wr_reg(6'h08, DFLT);
      for (int i = 0; i < 16; i++) begin
         wr_reg(6'h10 + 6'(i), slot_adr(i));
         wr_reg(6'h20 + 6'(i), 32'h100 | 32'(slot_src(i)));
      end
      rd_reg(6'h27, v); check("R5 ctl readback", v, 32'h100 | 32'(slot_src(7)));

      // R5 single-slot sweep with R7/R8 push/pop
      for (int i = 0; i < 16; i++) begin
         wr_reg(6'h05, 32'h1 << slot_src(i));
         check("R5 irq low", 32'(irq_n_o), 0);
         check("R5 vec_o", vec_o, slot_adr(i));
         rd_reg(6'h07, v); check("R5 vector", v, slot_adr(i));
         check("R7 same level masked", 32'(irq_n_o), 1);
         wr_reg(6'h07, 32'h1234_5678);
         check("R8 pop reopens", 32'(irq_n_o), 0);
         wr_reg(6'h06, 32'h1 << slot_src(i));
         check("R10 cleared", 32'(irq_n_o), 1);
      end

      // R5 priority over neighbour pairs
      for (int i = 0; i < 15; i++) begin
         wr_reg(6'h05, (32'h1 << slot_src(i)) | (32'h1 << slot_src(i + 1)));
         rd_reg(6'h07, v); check("R5 pair priority", v, slot_adr(i));
         check("R7 lower masked", 32'(irq_n_o), 1);
         wr_reg(6'h07, 32'h0);
         wr_reg(6'h06, 32'hFFFF_FFFF);
      end

      // R6 default vector for unmapped source 1
      wr_reg(6'h05, 32'h2);
      check("R6 irq low", 32'(irq_n_o), 0);
      rd_reg(6'h07, v); check("R6 default", v, DFLT);
      check("R6 masked after read", 32'(irq_n_o), 1);
      wr_reg(6'h07, 32'h0);
      wr_reg(6'h06, 32'hFFFF_FFFF);

      // R7 nesting
      wr_reg(6'h05, 32'h1 << slot_src(5));
      rd_reg(6'h07, v); check("R7 enter 5", v, slot_adr(5));
      wr_reg(6'h05, 32'h1 << slot_src(9));
      check("R7 slot 9 blocked", 32'(irq_n_o), 1);
      wr_reg(6'h05, 32'h1 << slot_src(2));
      check("R7 slot 2 preempts", 32'(irq_n_o), 0);
      rd_reg(6'h07, v); check("R7 enter 2", v, slot_adr(2));
      check("R7 nested masked", 32'(irq_n_o), 1);
      wr_reg(6'h07, 32'hFFFF_FFFF);
      check("R8 pop to 5", 32'(irq_n_o), 0);
      wr_reg(6'h06, 32'h1 << slot_src(2));
      check("R8 level 5 still held", 32'(irq_n_o), 1);
      wr_reg(6'h07, 32'h0);
      check("R8 pop to idle", 32'(irq_n_o), 0);
      rd_reg(6'h07, v); check("R8 reenter 5", v, slot_adr(5));
      wr_reg(6'h07, 32'h0);
      wr_reg(6'h06, 32'hFFFF_FFFF);

      // R11 empty read does not push
      rd_reg(6'h07, v); check("R11 empty read", v, DFLT);
      wr_reg(6'h05, 32'h2);
      check("R11 default still open", 32'(irq_n_o), 0);
      wr_reg(6'h06, 32'hFFFF_FFFF);

      // R9 chain
      chain_vec_i = 32'hC0DE_0040; chain_irq_n_i = 1'b0; settle();
      check("R9 irq low", 32'(irq_n_o), 0);
      check("R9 vec_o", vec_o, 32'hC0DE_0040);
      rd_reg(6'h07, v); check("R9 vector", v, 32'hC0DE_0040);
      check("R9 chain masked", 32'(irq_n_o), 1);
      wr_reg(6'h07, 32'h0);
      check("R9 reopened", 32'(irq_n_o), 0);
      wr_reg(6'h05, 32'h1 << slot_src(3));
      rd_reg(6'h07, v); check("R9 local first", v, slot_adr(3));
      wr_reg(6'h07, 32'h0);
      wr_reg(6'h06, 32'hFFFF_FFFF);
      chain_irq_n_i = 1'b1; chain_vec_i = '0; settle();
      check("R10 chain idle", 32'(irq_n_o), 1);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule